// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets a host drive a clause-22 MDIO management transaction to an external PHY through a single 32-bit command/status word. The host writes one word that holds the opcode, PHY address, register address, write data and an interrupt enable. The engine then generates the complete serial frame on MDC/MDIO. When the frame ends it sets the ready flag in the same word. For a read, the 16 bits sampled from the PHY replace the low half of the word.

MDC comes from a divider of the system clock and stays high between frames. On reads the engine releases MDIO from the turnaround onward and samples the line on each rising MDC edge. The default divider gives a 2.5 MHz MDC from a 50 MHz clock. At that rate a whole frame takes 25.6 µs, well inside a 64 µs host polling window.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the status word reads 0x1000_0000 (ready set, every other bit zero), irq is low, mdc is high and mdio_oe is low.
- R2: A command written while ready is set is taken. On the next cycle the status word shows command bits 29:0 with bit 28 (ready) cleared and bits 31:30 zero, and irq is low.
- R3: Each frame is 64 MDC bits, most significant bit first: 32 ones, start 01, opcode (10 for read, 01 for write), PHY address from command bits 25:21, register address from bits 20:16, two turnaround bits, then 16 data bits. For a write, the turnaround is 10 and the data comes from command bits 15:0.
- R4: On a write, mdio_oe is high for all 64 bits. On a read, mdio_oe is high for the first 46 bits and low for the turnaround and data bits.
- R5: On a read, mdio_i is sampled on the rising MDC edge of each of the 16 data bits. At completion the samples appear in status bits 15:0, first bit in bit 15. On a write, bits 15:0 keep the written data.
- R6: Ready is set exactly 128*MDC_HALF+1 clock cycles after the cycle in which the command was taken, after 64 MDC rising edges.
- R7: MDC is high whenever no frame is running. During a frame each MDC half period lasts MDC_HALF clock cycles.
- R8: irq is high exactly when ready is set and command bit 29 (interrupt enable) is set.
- R9: A write while ready is clear is ignored: the status word and the frame in progress are unchanged.
- R10: A command with neither bit 26 (write) nor bit 27 (read) set produces no frame, and ready is set again one cycle after ready is cleared. When both bits are set, the read takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word |
| cmd_status | output | 32 | Command/status word as read by the host |
| irq | output | 1 | Completion interrupt (level) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest case to reach from the ports is a host write that arrives while a frame is in flight. Its effect would only show up later, as a corrupted frame or a wrong final status. The bench issues a second, different command partway through a read. It then checks every captured frame bit and the completed status word against the first command alone. A model PHY in the bench drives distinct turnaround and data patterns, so that bit ordering and the sampling edge on reads are exposed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int unsigned CMD_W      = 32;
    localparam int unsigned DATA_W     = 16;
    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned FRAME_BITS = 64;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
    localparam int unsigned PRE_BITS   = 32;
    localparam int unsigned TA_FIRST   = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int unsigned DATA_FIRST = TA_FIRST + 2;

    localparam int unsigned B_REG_LO = DATA_W;
    localparam int unsigned B_PHY_LO = DATA_W + ADDR_W;
    localparam int unsigned B_WR     = 26;
    localparam int unsigned B_RD     = 27;
    localparam int unsigned B_RDY    = 28;
    localparam int unsigned B_IE     = 29;

    typedef enum logic { SQ_IDLE, SQ_RUN } seq_state_e;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              is_rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] rsel,
        input logic [DATA_W-1:0] wd
    );
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] body;
        op   = is_rd ? 2'b10 : 2'b01;
        ta   = is_rd ? 2'b11 : 2'b10;
        body = is_rd ? {DATA_W{1'b1}} : wd;
        return {{PRE_BITS{1'b1}}, 2'b01, op, phy, rsel, ta, body};
    endfunction
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int unsigned MDC_HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t d, q;

    always_comb begin
        d = q;
        tick = 1'b0;
        if (!run) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(MDC_HALF - 1)) begin
            d.cnt = '0;
            tick  = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int unsigned MDC_HALF = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_rd,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] rsel,
    input  logic [DATA_W-1:0] wd,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    typedef struct packed {
        seq_state_e            st;
        logic                  mdc;
        logic                  oe;
        logic                  dout;
        logic                  rdop;
        logic                  done;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sr;
        logic [DATA_W-1:0]     rd;
    } seq_t;

    seq_t d, q;
    logic tick;

    mdio_mdc_div #(.MDC_HALF(MDC_HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.st == SQ_RUN),
        .tick (tick)
    );

    always_comb begin
        d = q;
        d.done = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                d.mdc = 1'b1;
                d.oe  = 1'b0;
                if (start) begin
                    d.st   = SQ_RUN;
                    d.sr   = build_frame(is_rd, phy, rsel, wd);
                    d.idx  = '0;
                    d.rdop = is_rd;
                    d.rd   = '0;
                end
            end
            default: begin
                if (tick) begin
                    if (q.mdc) begin
                        d.mdc  = 1'b0;
                        d.dout = q.sr[FRAME_BITS-1];
                        d.oe   = !q.rdop || (q.idx < IDX_W'(TA_FIRST));
                    end else begin
                        d.mdc = 1'b1;
                        d.sr  = q.sr << 1;
                        if (q.rdop && q.idx >= IDX_W'(DATA_FIRST))
                            d.rd = {q.rd[DATA_W-2:0], mdio_i};
                        if (q.idx == IDX_W'(FRAME_BITS - 1)) begin
                            d.st   = SQ_IDLE;
                            d.done = 1'b1;
                            d.oe   = 1'b0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= SQ_IDLE;
            q.mdc  <= 1'b1;
            q.dout <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st == SQ_RUN);
    assign done    = q.done;
    assign rdata   = q.rd;
    assign mdc     = q.mdc;
    assign mdio_o  = q.dout;
    assign mdio_oe = q.oe;

    // R7: clock parked high outside frames
    a_r7_mdc_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_IDLE) |-> q.mdc);
    // R4: line released through turnaround and data on reads
    a_r4_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_RUN && q.rdop && !q.mdc && q.idx >= IDX_W'(TA_FIRST)) |-> !q.oe);
    // R6: completion only after the last bit
    a_r6_done_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($past(q.idx) == IDX_W'(FRAME_BITS - 1)));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_pkg::*;
#(
    parameter int unsigned MDC_HALF = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_status,
    output logic        irq,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [CMD_W-1:0] stat;
        logic             nop;
        logic             irq;
    } top_t;

    top_t d, q;
    logic take, start, seq_busy, seq_done;
    logic [DATA_W-1:0] seq_rd;

    assign take  = cmd_wr && q.stat[B_RDY];
    assign start = take && (cmd_wdata[B_RD] || cmd_wdata[B_WR]);

    mdio_frame_seq #(.MDC_HALF(MDC_HALF)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .is_rd  (cmd_wdata[B_RD]),
        .phy    (cmd_wdata[B_PHY_LO +: ADDR_W]),
        .rsel   (cmd_wdata[B_REG_LO +: ADDR_W]),
        .wd     (cmd_wdata[DATA_W-1:0]),
        .mdio_i (mdio_i),
        .busy   (seq_busy),
        .done   (seq_done),
        .rdata  (seq_rd),
        .mdc    (mdc),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe)
    );

    always_comb begin
        d = q;
        if (take) begin
            d.stat = {2'b00, cmd_wdata[B_IE], 1'b0, cmd_wdata[B_RD:0]};
            d.nop  = !(cmd_wdata[B_RD] || cmd_wdata[B_WR]);
        end else if (q.nop) begin
            d.stat[B_RDY] = 1'b1;
            d.nop         = 1'b0;
        end else if (seq_done) begin
            d.stat[B_RDY] = 1'b1;
            if (q.stat[B_RD])
                d.stat[DATA_W-1:0] = seq_rd;
        end
        d.irq = d.stat[B_RDY] && d.stat[B_IE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q             <= '0;
            q.stat[B_RDY] <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cmd_status = q.stat;
    assign irq        = q.irq;

    // R2: taking a command drops ready
    a_r2_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_status[B_RDY]) |=> !cmd_status[B_RDY]);
    // R8: interrupt only with enable
    a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> cmd_status[B_IE]);
    // R9: busy-time writes leave the command fields alone
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_status[B_RDY]) |=> $stable(cmd_status[31:16]));
    // R6: no frame activity once ready is back
    a_r6_idle_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_status[B_RDY] |-> !seq_busy);
endmodule

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
    localparam int HALF = 3;
    localparam int NV   = 6;
    // {command word, PHY response for reads}
    localparam logic [47:0] VEC [NV] = '{
        {32'h2422_A5C3, 16'h0000},
        {32'h0BFF_0000, 16'h8001},
        {32'h0400_FFFF, 16'h0000},
        {32'h0945_0000, 16'h0000},
        {32'h282A_0000, 16'h1234},
        {32'h06AA_0000, 16'h5A0F}
    };

    logic clk = 0, rst_n = 0, cmd_wr = 0, mdio_i = 1;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_status;
    logic irq, mdc, mdio_o, mdio_oe;
    int checks = 0, errors = 0;

    mdio_cmd_engine #(.MDC_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_status(cmd_status), .irq(irq), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    // Bus monitor and PHY model, evaluated away from the active edge
    logic [15:0] resp = '0;
    logic [63:0] fb, fo;
    int falls = 0, rises = 0, cyc = 0, last_fall = -1, per_bad = 0;
    logic mdc_prev = 1;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (mdc_prev && !mdc) begin
                if (last_fall >= 0 && falls > 0 && (cyc - last_fall) != 2 * HALF) per_bad++;
                last_fall = cyc;
                if (falls < 64) begin
                    fb[63 - falls] = mdio_o;
                    fo[63 - falls] = mdio_oe;
                    if (falls >= 48)      mdio_i = resp[63 - falls];
                    else if (falls == 47) mdio_i = 1'b0;
                    else                  mdio_i = 1'b1;
                end
                falls++;
            end
            if (!mdc_prev && mdc) rises++;
            mdc_prev = mdc;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [31:0] cmd, input logic [15:0] r, input bit busy_poke);
        logic [31:0] exp;
        logic [63:0] fr;
        logic rd, wr;
        int n;
        rd = cmd[27]; wr = cmd[26] && !rd;
        resp = r; falls = 0; rises = 0; per_bad = 0; last_fall = -1;
        fb = '1; fo = '0;
        @(negedge clk); cmd_wr = 1; cmd_wdata = cmd;
        @(negedge clk); cmd_wr = 0; n = 1;
        chk("R2 status after write", {32'h0, cmd_status}, {32'h0, cmd & 32'h2FFF_FFFF});
        chk("R2 irq low after write", {63'h0, irq}, 64'h0);
        while (!cmd_status[28] && n < 2000) begin
            if (busy_poke && n == 100) begin
                cmd_wr = 1; cmd_wdata = 32'h2C00_BEEF;
            end
            @(negedge clk); cmd_wr = 0; n++;
        end
        exp = (cmd & 32'h2FFF_FFFF) | 32'h1000_0000;
        if (rd) exp[15:0] = r;
        chk("R5 final status", {32'h0, cmd_status}, {32'h0, exp});
        chk("R8 irq", {63'h0, irq}, {63'h0, cmd[29]});
        if (rd || wr) begin
            fr = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, cmd[25:16], 2'b10, cmd[15:0]};
            chk("R6 ready latency", 64'(n), 64'(128 * HALF + 2));
            chk("R6 rising edge count", 64'(rises), 64'd64);
            chk("R7 mdc half period", 64'(per_bad), 64'd0);
            chk("R7 mdc idle high", {63'h0, mdc}, 64'h1);
            if (rd) begin
                chk("R3 read frame bits", fb[63:18], fr[63:18]);
                chk("R4 read output enable", fo, {{46{1'b1}}, 18'h0});
            end else begin
                chk("R3 write frame bits", fb, fr);
                chk("R4 write output enable", fo, '1);
            end
        end else begin
            chk("R10 nop latency", 64'(n), 64'd2);
            chk("R10 nop no frame", 64'(falls), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", {32'h0, cmd_status}, 64'h1000_0000);
        chk("R1 reset irq/mdc/oe", {61'h0, irq, mdc, mdio_oe}, 64'b010);
        for (int i = 0; i < NV; i++)
            run_cmd(VEC[i][47:16], VEC[i][15:0], 1'b0);
        // R9: a write during a read frame is dropped
        run_cmd(32'h0862_0000, 16'hC3A5, 1'b1);
        // R10: no opcode bits, with and without interrupt enable
        run_cmd(32'h2012_3456, 16'h0000, 1'b0);
        run_cmd(32'h001F_0001, 16'h0000, 1'b0);
        // R10: both opcode bits set, read wins
        run_cmd(32'h0C21_7777, 16'h0F0F, 1'b0);
        // R9: a write after completion is accepted again
        run_cmd(32'h0401_0102, 16'h0000, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule